// File: doc/BRIEF.md
# IrDA Transceiver Control Sequencer

This block is the clocked digital control path of an infrared transceiver front end. It takes a transmit data level, a shutdown request and a digitised "optical pulse seen" flag. From these it drives an emitter enable, a receive data line with a separate output enable for a tri-state pad, and a shutdown status flag. The analog front end (drive current, amplifier, gain control and detection thresholds) sits outside the block. The block only decides when the emitter may fire and what the receive line shows.

Every input first passes through a two-flop synchroniser. Each duration is a nanosecond parameter that is turned into a clock-cycle count from `CLK_HZ`, rounded up. An optical rising edge becomes a receive pulse of fixed width, active low. While the emitter fires, and for a receiver settling period after it stops, the receive path stays quiet. A transmit level held for too long trips an eye-safety cut-off. A shutdown request takes effect only after a grace delay. While that delay is running, a falling transmit edge returns one identification pulse on the receive line. All pins are plain levels with no handshake: the block samples every input on every clock and cannot stall its source.

Top module: `irx_ctrl_top`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `emit_en_o`=0, `rx_data_o`=1, `rx_oe_o`=1 and `sd_active_o`=0.
- R2: Outside shutdown, `emit_en_o` equals `tx_data_i` delayed by two clock edges. A falling transmit edge with the shutdown request low produces no receive pulse.
- R3: A rising edge on `opt_det_i` outside shutdown and outside the quiet period drives `rx_data_o` low for exactly PULSE cycles (ceil(RX_PULSE_NS·CLK_HZ/1e9)). The low level starts three clock edges after the input rises. Its width does not depend on how long the input stays high.
- R4: A receive trigger that arrives while a pulse is in progress is ignored: the pulse is neither restarted nor lengthened.
- R5: While `emit_en_o` is 1, `rx_data_o` is 1, even if a pulse was already running or an optical edge arrives.
- R6: After the emitter turns off, optical edges are ignored for exactly LAT cycles, counted from the first cycle with the emitter off. LAT is derived from LATENCY_NS, which is clamped to at most 200 µs.
- R7: If the synchronised transmit level stays high for LIM cycles, the emitter is forced off until the transmit level returns low. After that the next high level enables it again. LIM is derived from EYE_LIMIT_NS, which is clamped to at least 23 µs.
- R8: Once the synchronised shutdown request has been high for SDLY cycles, `sd_active_o` becomes 1, `rx_oe_o` becomes 0 and `emit_en_o` is held at 0.
- R9: In shutdown, optical edges and transmit edges produce no receive pulse.
- R10: While the shutdown request is high but shutdown is not yet active, a falling transmit edge produces exactly one PULSE-cycle low pulse on `rx_data_o`, starting three edges after the fall.
- R11: When the shutdown request goes low, `sd_active_o` clears three clock edges later and `rx_oe_o` returns to 1. Any new request must wait the full SDLY cycles again, even if an earlier request was interrupted partway.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| tx_data_i | input | 1 | Transmit data level, high = emit |
| sd_req_i | input | 1 | Shutdown request, active high |
| opt_det_i | input | 1 | Digitised optical detection flag |
| emit_en_o | output | 1 | Emitter enable, active high |
| rx_data_o | output | 1 | Receive data, idle high, pulses low |
| rx_oe_o | output | 1 | Receive pad output enable, 0 lets the pad float |
| sd_active_o | output | 1 | High while in shutdown |

## Verification
The bench keeps a 50 MHz clock and shortens the shutdown delay to 20 µs (1000 cycles), so that complete shutdown, exit and re-entry sequences fit in a short run. It sets the eye-safety limit to 10 µs and the receiver latency to 300 µs. Both values lie outside their permitted ranges, so the observed cut-off at 1150 cycles and the quiet window of 10000 cycles check the clamps directly. The 400 ns pulse (20 cycles) is long enough that a second optical edge can land inside it, and short enough that both a shorter and a longer optical input can be compared against it.

// File: rtl/irx_pkg.sv
`timescale 1ns/1ps
package irx_pkg;

  localparam int unsigned EYE_MIN_NS = 23_000;
  localparam int unsigned LAT_MAX_NS = 200_000;

  // Cycles needed to cover ns nanoseconds at clk_hz, rounded up, minimum 1.
  function automatic int unsigned ns_to_cyc(input int unsigned clk_hz, input int unsigned ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(clk_hz) * longint'(ns);
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 0) cyc = 1;
    return 32'(cyc);
  endfunction

  function automatic int unsigned clamp_lo(input int unsigned v, input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

  function automatic int unsigned clamp_hi(input int unsigned v, input int unsigned hi);
    return (v > hi) ? hi : v;
  endfunction

endpackage

// File: rtl/irx_sync.sv
`timescale 1ns/1ps
module irx_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[g];
        s2 <= s1;
      end
    end
    assign q[g] = s2;
  end
endmodule

// File: rtl/irx_shutdown.sv
`timescale 1ns/1ps
module irx_shutdown #(
  parameter int unsigned DLY = 50_000,
  parameter int unsigned W   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sd_s,
  output logic active_o,
  output logic window_o
);
  logic [W-1:0] cnt;
  logic         act;

  always_ff @(posedge clk) begin
    if (rst || !sd_s) begin
      cnt <= '0;
      act <= 1'b0;
    end else if (!act) begin
      if (cnt == W'(DLY - 1)) act <= 1'b1;
      else                    cnt <= cnt + W'(1);
    end
  end

  assign active_o = act;
  assign window_o = sd_s & ~act;

  // R11: a released request always leaves shutdown on the next edge
  p_exit_on_release_r11: assert property (@(posedge clk) disable iff (rst)
    !sd_s |=> !act);

  // R8: shutdown is entered only after the full delay has been counted
  p_enter_after_delay_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(act) |-> ($past(cnt) == W'(DLY - 1) && $past(sd_s)));
endmodule

// File: rtl/irx_emit_guard.sv
`timescale 1ns/1ps
module irx_emit_guard #(
  parameter int unsigned LIM = 4000,
  parameter int unsigned LW  = 12,
  parameter int unsigned LAT = 2500,
  parameter int unsigned QW  = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_s,
  input  logic sd_active,
  output logic emit_o,
  output logic quiet_o
);
  logic [LW-1:0] on_cnt;
  logic          tripped;
  logic          emit_d;
  logic [QW-1:0] q_cnt;

  // on-time limiter
  always_ff @(posedge clk) begin
    if (rst || !tx_s) begin
      on_cnt  <= '0;
      tripped <= 1'b0;
    end else if (!tripped) begin
      if (on_cnt == LW'(LIM - 1)) tripped <= 1'b1;
      else                        on_cnt  <= on_cnt + LW'(1);
    end
  end

  assign emit_o = tx_s & ~tripped & ~sd_active;

  // receiver quiet window after the emitter stops
  always_ff @(posedge clk) begin
    if (rst) begin
      emit_d <= 1'b0;
      q_cnt  <= '0;
    end else begin
      emit_d <= emit_o;
      if (emit_d && !emit_o)  q_cnt <= QW'(LAT - 1);
      else if (q_cnt != '0)   q_cnt <= q_cnt - QW'(1);
    end
  end

  assign quiet_o = emit_o | emit_d | (q_cnt != '0);

  // R7: once tripped, the cut-off holds for as long as transmit stays high
  p_trip_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (tripped && tx_s) |=> tripped);

  // R7: a low transmit level re-arms the limiter
  p_trip_rearm_r7: assert property (@(posedge clk) disable iff (rst)
    !tx_s |=> (!tripped && on_cnt == '0));
endmodule

// File: rtl/irx_rx_mono.sv
`timescale 1ns/1ps
module irx_rx_mono #(
  parameter int unsigned PW  = 20,
  parameter int unsigned PWW = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic kill,
  output logic low_o
);
  logic [PWW-1:0] p_cnt;

  always_ff @(posedge clk) begin
    if (rst || kill)         p_cnt <= '0;
    else if (p_cnt != '0)    p_cnt <= p_cnt - PWW'(1);
    else if (trig)           p_cnt <= PWW'(PW);
  end

  assign low_o = (p_cnt != '0);

  // R4: a running pulse only counts down, a trigger cannot reload it
  p_no_retrigger_r4: assert property (@(posedge clk) disable iff (rst)
    (p_cnt != '0 && !kill) |=> (p_cnt == $past(p_cnt) - PWW'(1)));
endmodule

// File: rtl/irx_ctrl_top.sv
`timescale 1ns/1ps
module irx_ctrl_top import irx_pkg::*; #(
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned SD_DELAY_NS  = 1_000_000,
  parameter int unsigned EYE_LIMIT_NS = 80_000,
  parameter int unsigned LATENCY_NS   = 50_000,
  parameter int unsigned RX_PULSE_NS  = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_data_i,
  input  logic sd_req_i,
  input  logic opt_det_i,
  output logic emit_en_o,
  output logic rx_data_o,
  output logic rx_oe_o,
  output logic sd_active_o
);
  localparam int unsigned SD_CYC  = ns_to_cyc(CLK_HZ, SD_DELAY_NS);
  localparam int unsigned LIM_CYC = ns_to_cyc(CLK_HZ, clamp_lo(EYE_LIMIT_NS, EYE_MIN_NS));
  localparam int unsigned LAT_CYC = ns_to_cyc(CLK_HZ, clamp_hi(LATENCY_NS, LAT_MAX_NS));
  localparam int unsigned PW_CYC  = ns_to_cyc(CLK_HZ, RX_PULSE_NS);
  localparam int unsigned SD_W    = $clog2(SD_CYC + 1);
  localparam int unsigned LIM_W   = $clog2(LIM_CYC + 1);
  localparam int unsigned LAT_W   = $clog2(LAT_CYC + 1);
  localparam int unsigned PW_W    = $clog2(PW_CYC + 1);

  logic [2:0] raw, syn;
  logic tx_s, sd_s, opt_s;
  logic tx_d, opt_d;
  logic sd_act, sd_win;
  logic emit, quiet;
  logic opt_trig, id_trig, rx_low;

  assign raw = {opt_det_i, sd_req_i, tx_data_i};

  irx_sync #(.W(3)) sync_i (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );
  assign tx_s  = syn[0];
  assign sd_s  = syn[1];
  assign opt_s = syn[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_d  <= 1'b0;
      opt_d <= 1'b0;
    end else begin
      tx_d  <= tx_s;
      opt_d <= opt_s;
    end
  end

  irx_shutdown #(.DLY(SD_CYC), .W(SD_W)) sd_i (
    .clk(clk), .rst(rst), .sd_s(sd_s), .active_o(sd_act), .window_o(sd_win)
  );

  irx_emit_guard #(.LIM(LIM_CYC), .LW(LIM_W), .LAT(LAT_CYC), .QW(LAT_W)) guard_i (
    .clk(clk), .rst(rst), .tx_s(tx_s), .sd_active(sd_act),
    .emit_o(emit), .quiet_o(quiet)
  );

  assign opt_trig = opt_s & ~opt_d & ~sd_act & ~quiet;
  assign id_trig  = tx_d & ~tx_s & sd_win;

  irx_rx_mono #(.PW(PW_CYC), .PWW(PW_W)) mono_i (
    .clk(clk), .rst(rst), .trig(opt_trig | id_trig), .kill(sd_act), .low_o(rx_low)
  );

  assign emit_en_o   = emit;
  assign rx_data_o   = ~rx_low | emit;
  assign rx_oe_o     = ~sd_act;
  assign sd_active_o = sd_act;

  // R8: in shutdown the emitter is off and the receive pad is released
  p_shutdown_pins_r8: assert property (@(posedge clk) disable iff (rst)
    sd_active_o |-> (!rx_oe_o && !emit_en_o));

  // R5/R6: no optical trigger is accepted while the emitter fires
  p_no_opt_while_emit_r5: assert property (@(posedge clk) disable iff (rst)
    emit |-> !opt_trig);

  // R9: no pulse can start while shut down
  p_no_pulse_in_sd_r9: assert property (@(posedge clk) disable iff (rst)
    sd_act |=> !rx_low);
endmodule

// File: tb/irx_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module irx_ctrl_top_tb_top;
  localparam int unsigned SDLY = 1000;   // 20 us at 50 MHz
  localparam int unsigned LIM  = 1150;   // 10 us requested, clamped to 23 us
  localparam int unsigned LAT  = 10000;  // 300 us requested, clamped to 200 us
  localparam int unsigned PW   = 20;     // 400 ns

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx = 1'b0, sd = 1'b0, opt = 1'b0;
  logic emit, rxd, oe, sda;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irx_ctrl_top #(
    .CLK_HZ(50_000_000), .SD_DELAY_NS(20_000), .EYE_LIMIT_NS(10_000),
    .LATENCY_NS(300_000), .RX_PULSE_NS(400)
  ) dut_i (
    .clk(clk), .rst(rst), .tx_data_i(tx), .sd_req_i(sd), .opt_det_i(opt),
    .emit_en_o(emit), .rx_data_o(rxd), .rx_oe_o(oe), .sd_active_o(sda)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic settle();
    tx = 1'b0; opt = 1'b0; sd = 1'b0;
    step(LAT + 10);
  endtask

  // drive opt high now, check the receive line cycle by cycle
  task automatic opt_run(input string tag, input int width, input int n, input bit expect_pulse);
    opt = 1'b1;
    for (int i = 1; i <= n; i++) begin
      step(1);
      if (i == width) opt = 1'b0;
      chk(tag, rxd, (expect_pulse && i >= 3 && i <= PW + 2) ? 1'b0 : 1'b1);
    end
    opt = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 emit in reset", emit, 1'b0);
    chk("R1 rxd in reset", rxd, 1'b1);
    rst = 1'b0;
    step(1);
    chk("R1 emit", emit, 1'b0);
    chk("R1 rxd", rxd, 1'b1);
    chk("R1 oe", oe, 1'b1);
    chk("R1 sd", sda, 1'b0);
  endtask

  task automatic t_follow();
    tx = 1'b1;
    step(1); chk("R2 emit lag", emit, 1'b0);
    step(1); chk("R2 emit on", emit, 1'b1);
    step(8);
    tx = 1'b0;
    step(1); chk("R2 emit hold", emit, 1'b1);
    step(1); chk("R2 emit off", emit, 1'b0);
    for (int i = 0; i < PW + 4; i++) begin
      step(1); chk("R2 no id pulse outside window", rxd, 1'b1);
    end
    settle();
  endtask

  task automatic t_pulse();
    opt_run("R3 short input", 1, PW + 6, 1'b1);
    step(10);
    opt_run("R3 long input", 3 * PW, 3 * PW + 4, 1'b1);
    step(10);
  endtask

  task automatic t_retrigger();
    opt = 1'b1;
    for (int i = 1; i <= PW + 12; i++) begin
      step(1);
      if (i == 3) opt = 1'b0;
      if (i == 6) opt = 1'b1;
      if (i == PW + 8) opt = 1'b0;
      chk("R4 no retrigger", rxd, (i >= 3 && i <= PW + 2) ? 1'b0 : 1'b1);
    end
    step(10);
  endtask

  task automatic t_forced_high();
    opt = 1'b1;
    for (int i = 1; i <= PW + 4; i++) begin
      step(1);
      if (i == 2) opt = 1'b0;
      if (i == 5) tx = 1'b1;
      chk("R5 rxd during emit", rxd, (i >= 3 && i <= 6) ? 1'b0 : 1'b1);
    end
    opt_run("R5 edge while emitting", 2, PW + 5, 1'b0);
    chk("R5 emitter still on", emit, 1'b1);
    settle();
  endtask

  task automatic t_latency();
    tx = 1'b1; step(10); tx = 1'b0;
    step(LAT - 1);
    opt_run("R6 last quiet cycle", 2, PW + 5, 1'b0);
    settle();
    tx = 1'b1; step(10); tx = 1'b0;
    step(LAT);
    opt_run("R6 first open cycle", 2, PW + 5, 1'b1);
    settle();
  endtask

  task automatic t_eye();
    tx = 1'b1;
    step(LIM + 1); chk("R7 emit at limit", emit, 1'b1);
    step(1);       chk("R7 emit cut", emit, 1'b0);
    step(40);      chk("R7 cut held", emit, 1'b0);
    tx = 1'b0; step(5);
    tx = 1'b1; step(2); chk("R7 re-armed", emit, 1'b1);
    tx = 1'b0;
    settle();
  endtask

  task automatic t_shutdown();
    sd = 1'b1; tx = 1'b1;
    step(SDLY + 1);
    chk("R8 not yet shut", sda, 1'b0);
    chk("R8 emit in window", emit, 1'b1);
    chk("R8 oe in window", oe, 1'b1);
    step(1);
    chk("R8 shut", sda, 1'b1);
    chk("R8 oe released", oe, 1'b0);
    chk("R8 emit off", emit, 1'b0);
    tx = 1'b0;
    step(4);
    opt_run("R9 optical ignored", 2, PW + 5, 1'b0);
    chk("R9 oe still released", oe, 1'b0);
    sd = 1'b0;
    step(2); chk("R11 exit latency", sda, 1'b1);
    step(1); chk("R11 exited", sda, 1'b0);
    chk("R11 oe back", oe, 1'b1);
    // interrupted request, then a fresh one needs the full delay
    sd = 1'b1; step(SDLY / 2);
    sd = 1'b0; step(2);
    sd = 1'b1;
    step(SDLY + 1); chk("R11 full delay again", sda, 1'b0);
    step(1);        chk("R11 re-entered", sda, 1'b1);
    settle();
  endtask

  task automatic t_ident();
    sd = 1'b1; step(5);
    tx = 1'b1; step(10);
    tx = 1'b0;
    for (int i = 1; i <= PW + 6; i++) begin
      step(1);
      chk("R10 id pulse", rxd, (i >= 3 && i <= PW + 2) ? 1'b0 : 1'b1);
    end
    chk("R10 still in window", sda, 1'b0);
    settle();
  endtask

  initial begin
    step(5);
    t_reset();
    step(5);
    t_follow();
    t_pulse();
    t_retrigger();
    t_forced_high();
    t_latency();
    t_eye();
    t_shutdown();
    t_ident();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule